// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers eighteen interrupt request lines, latches each rising edge as a pending event and presents one winner to a CPU as a request strobe with a source index. The sources are arranged into six groups, and each group is given one of four priority levels. Source `i` belongs to group `i mod 6`. The winner is the enabled pending source whose group has the highest level. Among sources at the same level, the lowest source index wins.

The CPU takes a request by pulsing an acknowledge. This clears that source's pending flag and marks its level as in service. It signals the end of a handler with a return pulse, which releases the highest level in service. A new request is offered only when its level is strictly above every level in service, so handlers nest at most four deep. While the system sleeps, any enabled pending event raises a wake output so that a power controller can bring the system back to the active mode. Software sets the enables and priorities through a small write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all pending flags, enables, the global enable, the group levels and the in-service state are cleared, and `req_o` and `wake_o` are low.
- R2: A write with `cfg_addr`=0 loads the per-source enable mask: bit i enables source i. With `cfg_addr`=1, bit 0 loads the global enable. With `cfg_addr`=2, bits [2g+1:2g] load the level of group g, where 3 is the highest level and 0 the lowest. The new settings take effect from the cycle after the write.
- R3: A source becomes pending at the first clock edge at which `irq_i[i]` is seen high after being low. The flag stays set until that source is acknowledged. A line held high does not set the flag again.
- R4: `ack_i` sampled while `req_o` is high clears the pending flag of `vec_o` and marks that source's level as in service. `ack_i` while `req_o` is low has no effect. A new rising edge on the same source in the acknowledge cycle leaves that source pending.
- R5: A source is eligible when it is pending, its enable bit is set and the global enable is set. Among eligible sources the highest group level wins, and a tie goes to the lowest source index.
- R6: `req_o` is high only when the winner's level is strictly greater than every level in service, or when no level is in service.
- R7: `reti_i` releases the highest level in service. Lower-level sources can then be requested from the next cycle.
- R8: `wake_o` is high exactly when `sleep_i` is high and at least one source is eligible, whatever is in service.
- R9: A disabled source keeps its pending flag. It is neither requested nor allowed to wake, and it is requested once it is enabled.
- R10: `req_o` and `vec_o` depend only on registered state. They stay constant through a whole cycle and follow a new edge on `irq_i` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 18 | Interrupt request lines, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select (0 enables, 1 global enable, 2 group levels) |
| cfg_wdata | input | 18 | Configuration write data |
| ack_i | input | 1 | CPU accepts the presented request |
| reti_i | input | 1 | CPU leaves the current handler |
| sleep_i | input | 1 | A sleep mode is active |
| req_o | output | 1 | Interrupt request strobe to the CPU |
| vec_o | output | 5 | Index of the requested source |
| wake_o | output | 1 | Wake request while sleeping |

## Verification
The bench first applies directed patterns. Two sources in one group show that the lowest index wins a tie. Sources in groups at different levels show that the group level outranks the index. A chain of acknowledges and returns exercises nesting, including a same-level event that must wait. A disabled source that is enabled later must still fire, and the wake output is toggled through sleep. A long random phase then mixes edges, held-high lines, stray acknowledges, returns and reconfiguration. A behavioural reference model compares the request, the index and the wake output every cycle, so ordering and nesting faults show up as mismatches.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 18,
  parameter int NGRP = 6,
  parameter int NLVL = 4,
  localparam int LW = $clog2(NLVL),
  localparam int VW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_i,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [NSRC-1:0] cfg_wdata,
  input  logic            ack_i,
  input  logic            reti_i,
  input  logic            sleep_i,
  output logic            req_o,
  output logic [VW-1:0]   vec_o,
  output logic            wake_o
);

  logic [NSRC-1:0]    irq_q, pend, en, elig, rise;
  logic               gie;
  logic [LW*NGRP-1:0] prio;
  logic [NLVL-1:0]    insvc, pop_mask, push_mask;
  logic               found, have_svc;
  logic [LW-1:0]      best_lvl, cur_lvl;
  logic [VW-1:0]      best_idx;

  assign elig = pend & en & {NSRC{gie}};
  assign rise = irq_i & ~irq_q;

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || prio[(i % NGRP)*LW +: LW] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = prio[(i % NGRP)*LW +: LW];
        best_idx = VW'(i);
      end
    end
  end

  always_comb begin
    have_svc = 1'b0;
    cur_lvl  = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (insvc[l]) begin
        have_svc = 1'b1;
        cur_lvl  = LW'(l);
      end
    end
  end

  assign req_o  = found && (!have_svc || best_lvl > cur_lvl);
  assign vec_o  = best_idx;
  assign wake_o = sleep_i && (|elig);

  assign pop_mask  = (reti_i && have_svc) ? (NLVL'(1) << cur_lvl) : '0;
  assign push_mask = (ack_i && req_o) ? (NLVL'(1) << best_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      pend  <= '0;
      en    <= '0;
      gie   <= 1'b0;
      prio  <= '0;
      insvc <= '0;
    end else begin
      irq_q <= irq_i;
      insvc <= (insvc & ~pop_mask) | push_mask;
      for (int i = 0; i < NSRC; i++) begin
        if (rise[i])
          pend[i] <= 1'b1;
        else if (ack_i && req_o && best_idx == VW'(i))
          pend[i] <= 1'b0;
      end
      if (cfg_we) begin
        case (cfg_addr)
          2'd0:    en   <= cfg_wdata;
          2'd1:    gie  <= cfg_wdata[0];
          2'd2:    prio <= cfg_wdata[LW*NGRP-1:0];
          default: ;
        endcase
      end
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !req_o && !wake_o);

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_o && !rise[vec_o]) |=> !pend[$past(vec_o)]);

  a_r5_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !req_o && !wake_o);

  a_r6_full_stack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    insvc[NLVL-1] |-> !req_o);

  a_r8_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> sleep_i);

  a_r10_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> vec_o < VW'(NSRC));

endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int NSRC = 18, NGRP = 6, NLVL = 4;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] irq_i = '0, cfg_wdata = '0;
  logic cfg_we = 0, ack_i = 0, reti_i = 0, sleep_i = 0;
  logic [1:0] cfg_addr = '0;
  logic req_o, wake_o;
  logic [4:0] vec_o;

  int n_chk = 0, n_bad = 0;

  prio_irq_ctrl dut (.*);

  always #10 clk = ~clk;

  bit m_pend[NSRC], m_en[NSRC], m_prev[NSRC], m_svc[NLVL];
  bit m_gie;
  int m_lvl[NGRP];

  function automatic void model_out(output bit r, output int v, output bit w);
    int cur = -1, bl = -1;
    bit any = 0;
    v = 0;
    for (int l = 0; l < NLVL; l++) if (m_svc[l]) cur = l;
    for (int i = 0; i < NSRC; i++)
      if (m_pend[i] && m_en[i] && m_gie) begin
        any = 1;
        if (m_lvl[i % NGRP] > bl) begin bl = m_lvl[i % NGRP]; v = i; end
      end
    r = any && bl > cur;
    w = sleep_i && any;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit r, w; int v, cur;
    if (!rst_n) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_en[i] = 0; m_prev[i] = 0; end
      foreach (m_svc[l]) m_svc[l] = 0;
      foreach (m_lvl[g]) m_lvl[g] = 0;
      m_gie = 0;
    end else begin
      model_out(r, v, w);
      cur = -1;
      for (int l = 0; l < NLVL; l++) if (m_svc[l]) cur = l;
      if (reti_i && cur >= 0) m_svc[cur] = 0;
      if (ack_i && r) begin m_pend[v] = 0; m_svc[m_lvl[v % NGRP]] = 1; end
      for (int i = 0; i < NSRC; i++) begin
        if (irq_i[i] && !m_prev[i]) m_pend[i] = 1;
        m_prev[i] = irq_i[i];
      end
      if (cfg_we) case (cfg_addr)
        2'd0: for (int i = 0; i < NSRC; i++) m_en[i] = cfg_wdata[i];
        2'd1: m_gie = cfg_wdata[0];
        2'd2: for (int g = 0; g < NGRP; g++) m_lvl[g] = cfg_wdata[2*g +: 2];
        default: ;
      endcase
    end
  end

  // R3 R5 R6 R8 R10: every-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    bit r, w; int v;
    model_out(r, v, w);
    chk(req_o == r, "R6 req_o", req_o, r);
    if (r) chk(vec_o == v, "R5 vec_o", vec_o, v);
    chk(wake_o == w, "R8 wake_o", wake_o, w);
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic cfg(int a, logic [NSRC-1:0] d);
    cfg_we = 1; cfg_addr = a[1:0]; cfg_wdata = d;
    tick(); cfg_we = 0;
  endtask

  task automatic pulse(int i);
    irq_i[i] = 1; tick(); irq_i[i] = 0;
  endtask

  task automatic ack();
    ack_i = 1; tick(); ack_i = 0;
  endtask

  task automatic reti();
    reti_i = 1; tick(); reti_i = 0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    chk(req_o == 0 && wake_o == 0, "R1 reset outputs", req_o, 0);
    rst_n = 1; tick();
    chk(req_o == 0, "R1 idle after reset", req_o, 0);

    // R2: group levels g0=1 g1=2 g2=3 g3=0 g4=1 g5=2
    cfg(2, 18'b10_01_00_11_10_01);
    cfg(0, '1);
    cfg(1, 1);

    // R5 tie: sources 6 and 0 share group 0
    irq_i[6] = 1; irq_i[0] = 1; tick(); irq_i = '0;
    chk(req_o && vec_o == 0, "R5 tie lowest index", vec_o, 0);
    ack();
    chk(req_o == 0, "R6 same level waits", req_o, 0);
    // R6 nest: source 2 (group 2, level 3) preempts
    pulse(2);
    chk(req_o && vec_o == 2, "R6 higher preempts", vec_o, 2);
    ack();
    reti();
    reti();
    chk(req_o && vec_o == 6, "R7 pending served after return", vec_o, 6);
    ack(); reti();

    // R3: held-high line does not retrigger
    irq_i[5] = 1; tick(); ack(); reti(); tick(3);
    chk(req_o == 0, "R3 level held no retrigger", req_o, 0);
    irq_i[5] = 0;

    // R4 stray ack ignored
    ack();
    chk(req_o == 0, "R4 stray ack", req_o, 0);

    // R9 disabled source stays pending
    cfg(0, ~(18'd1 << 9));
    pulse(9); tick(2);
    chk(req_o == 0, "R9 disabled not requested", req_o, 0);
    sleep_i = 1; tick();
    chk(wake_o == 0, "R9 disabled no wake", wake_o, 0);
    cfg(0, '1);
    chk(wake_o == 1, "R8 wake on enable", wake_o, 1);
    chk(req_o && vec_o == 9, "R9 served once enabled", vec_o, 9);
    sleep_i = 0; ack(); reti();

    // R10 latency: one clock from edge to request
    irq_i[13] = 1; #5;
    chk(req_o == 0, "R10 no combinational path", req_o, 0);
    tick(); irq_i[13] = 0;
    chk(req_o && vec_o == 13, "R10 next cycle", vec_o, 13);
    ack(); reti();

    // random phase
    for (int k = 0; k < 4000; k++) begin
      irq_i   = irq_i ^ ($urandom() & $urandom() & $urandom());
      ack_i   = ($urandom() % 3) == 0;
      reti_i  = ($urandom() % 4) == 0;
      sleep_i = $urandom() % 2;
      cfg_we  = ($urandom() % 25) == 0;
      cfg_addr = ($urandom() % 3);
      cfg_wdata = $urandom();
      if (cfg_addr == 1) cfg_wdata[0] = ($urandom() % 5) != 0;
      if (cfg_addr == 0) cfg_wdata = cfg_wdata | 18'($urandom());
      tick();
    end
    ack_i = 0; reti_i = 0; cfg_we = 0;
    tick(2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule